// File: doc/BRIEF.md
# Timed Interrupt Hold-Off Gate

This block sits on the path between the interrupt sources of a system and the interrupt inputs of a processor. Unprivileged code issues a start request with a cycle count. For that many clock cycles every interrupt line toward the processor is forced low. Software can then run a short read-modify-write sequence and read a busy flag afterwards. If the flag is still high, no interrupt could have been taken during the sequence.

The window is measured in clock cycles, because the gate has no view of the instruction stream. The length is chosen to cover the worst-case latency from an interrupt being raised to the processor acting on it. A compile-time ceiling limits how long unprivileged code can hold interrupts off. Any request above that ceiling is reduced to it.

Interrupt requests that arrive while the window is open are not lost. Each line has a sticky pending bit that collects requests during the window. The pending bits are released on the first cycle after the window closes. After that, the outputs follow the sources again.

Top module: `irq_mask_gate`

## Requirements
- R1: After reset the busy flag is 0, the counter is idle and every output line equals its input line.
- R2: While no window is open, each output line equals its input line in the same cycle, with no register in the path.
- R3: A start request sampled at a clock edge with length L, where 1 <= L <= MAX_LEN, raises the busy flag from the following cycle for exactly L consecutive cycles.
- R4: While the busy flag is 1, every output line is 0, whatever the input lines do.
- R5: A start request whose length is greater than MAX_LEN opens a window of exactly MAX_LEN cycles.
- R6: A start request of length 0 leaves the busy flag at 0 from the next cycle, including when a window was already open, which cancels that window.
- R7: A start request issued while a window is open reloads the full requested length (clamped per R5), counted from the next cycle.
- R8: An input line that is 1 during any cycle with busy = 1 drives its output line to 1 in the first cycle with busy = 0.
- R9: The pending state is cleared after that first unmasked cycle. From the second unmasked cycle on, each output equals its input.
- R10: While a window is open and no new start request arrives, the counter falls by exactly one per cycle and never exceeds MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to open or reload the hold-off window |
| len_i | input | LEN_W | Requested window length in cycles, sampled with start_i |
| irq_in | input | NUM_LINES | Interrupt request lines from the sources |
| irq_out | output | NUM_LINES | Gated interrupt lines toward the processor |
| busy_o | output | 1 | Status query result: 1 while the window counter is non-zero |

## Verification
A counter that is wrong by even one shows up as a busy flag that is one cycle too long or too short. It also shows up as an output line that is released one cycle early or late. The sweep over every requested length exposes both within the window being tested. A pending bit that is lost or that sticks shows up on the first or second unmasked cycle after the window closes. A gate that leaks shows up at the ports in the same cycle as the injected request.

// File: rtl/irq_mask_gate_pkg.sv
package irq_mask_gate_pkg;

  // Limit a requested length to the configured ceiling.
  function automatic int unsigned clamp_len(int unsigned req, int unsigned ceil_v);
    return (req > ceil_v) ? ceil_v : req;
  endfunction

endpackage

// File: rtl/mask_timer.sv
module mask_timer #(
  parameter int LEN_W   = 8,
  parameter int MAX_LEN = 64,
  parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o
);
  import irq_mask_gate_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (start_i) begin
      cnt_d = CNT_W'(clamp_len(int'(len_i), MAX_LEN));
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pend_hold.sv
module pend_hold #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy_i,
  input  logic [NUM_LINES-1:0] irq_i,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_LINES-1:0] pend_q, pend_d;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    // Collect while held off; drop once the held request has been shown.
    always_comb begin
      pend_d[g] = busy_i ? (pend_q[g] | irq_i[g]) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
      end else if (busy_i || pend_q[g]) begin
        pend_q[g] <= pend_d[g];
      end
    end

    assign irq_o[g] = busy_i ? 1'b0 : (irq_i[g] | pend_q[g]);
  end
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
  parameter int NUM_LINES = 32,
  parameter int LEN_W     = 8,
  parameter int MAX_LEN   = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_out,
  output logic                 busy_o
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy;

  mask_timer #(
    .LEN_W  (LEN_W),
    .MAX_LEN(MAX_LEN),
    .CNT_W  (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .len_i  (len_i),
    .cnt_o  (cnt_q),
    .busy_o (busy)
  );

  pend_hold #(
    .NUM_LINES(NUM_LINES)
  ) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .busy_i(busy),
    .irq_i (irq_in),
    .irq_o (irq_out)
  );

  assign busy_o = busy;
endmodule

// File: rtl/irq_mask_gate_chk.sv
module irq_mask_gate_chk #(
  parameter int NUM_LINES = 32,
  parameter int LEN_W     = 8,
  parameter int MAX_LEN   = 64,
  parameter int CNT_W     = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic [LEN_W-1:0]     len_i,
  input logic [NUM_LINES-1:0] irq_in,
  input logic [NUM_LINES-1:0] irq_out,
  input logic                 busy_o,
  input logic [CNT_W-1:0]     cnt_q
);
  // R4
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (irq_out == '0));

  // R3
  open_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && len_i != '0) |=> busy_o);

  // R6
  zero_len_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && len_i == '0) |=> !busy_o);

  // R10
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R10
  count_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= MAX_LEN);

  // R8
  held_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(busy_o)) |-> ((irq_out & $past(irq_in)) == $past(irq_in)));

  // R9
  follow_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> (irq_out == irq_in));
endmodule

bind irq_mask_gate irq_mask_gate_chk #(
  .NUM_LINES(NUM_LINES),
  .LEN_W    (LEN_W),
  .MAX_LEN  (MAX_LEN),
  .CNT_W    (CNT_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start_i(start_i),
  .len_i  (len_i),
  .irq_in (irq_in),
  .irq_out(irq_out),
  .busy_o (busy_o),
  .cnt_q  (cnt_q)
);

// File: tb/irq_mask_gate_bench.sv
`timescale 1ns/1ps
module irq_mask_gate_bench;
  localparam int NL  = 4;
  localparam int LW  = 4;
  localparam int MXL = 9;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [LW-1:0] len_i;
  logic [NL-1:0] irq_in;
  logic [NL-1:0] irq_out;
  logic          busy_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  irq_mask_gate #(.NUM_LINES(NL), .LEN_W(LW), .MAX_LEN(MXL)) u_irq_mask_gate (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .irq_in(irq_in), .irq_out(irq_out), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Open a window of requested length L and check every cycle of it.
  task automatic run_window(input int L);
    int eff;
    logic [NL-1:0] pat;
    eff = (L > MXL) ? MXL : L;
    pat = NL'((L % 15) + 1);
    @(negedge clk);
    start_i = 1'b1; len_i = LW'(L); irq_in = '0;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < eff; i++) begin
      irq_in = (i == eff / 2) ? pat : '0;
      #1;
      check(busy_o == 1'b1, (L > MXL) ? "R5 busy" : "R3 busy", busy_o, 1);
      check(irq_out == '0, "R4 gated", irq_out, 0);
      @(negedge clk);
    end
    irq_in = '0;
    #1;
    check(busy_o == 1'b0, (L == 0) ? "R6 idle" : "R3 end", busy_o, 0);
    if (eff > 0) check(irq_out == pat, "R8 release", irq_out, pat);
    @(negedge clk);
    #1;
    check(irq_out == '0, "R9 cleared", irq_out, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; len_i = '0; irq_in = '0;
    repeat (3) @(negedge clk);
    #1;
    check(busy_o == 1'b0, "R1 busy", busy_o, 0);
    check(irq_out == '0, "R1 out", irq_out, 0);
    rst_n = 1'b1;

    // R2: direct path for every input pattern
    for (int p = 0; p < (1 << NL); p++) begin
      @(negedge clk);
      irq_in = NL'(p);
      #1;
      check(irq_out == NL'(p), "R2 pass", irq_out, p);
    end

    // R3/R5/R8/R9: sweep every encodable length
    for (int L = 0; L < (1 << LW); L++) run_window(L);

    // R9: a source that stays high keeps its line high after release
    @(negedge clk);
    start_i = 1'b1; len_i = LW'(3); irq_in = 4'b0101;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(irq_out == 4'b0101, "R8 held level", irq_out, 5);
    repeat (2) @(negedge clk);
    #1;
    check(irq_out == 4'b0101, "R9 follow", irq_out, 5);
    irq_in = '0;

    // R7: reload while open
    @(negedge clk);
    start_i = 1'b1; len_i = LW'(6);
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    start_i = 1'b1; len_i = LW'(6);
    @(negedge clk);
    start_i = 1'b0;
    begin
      int n;
      n = 0;
      while (busy_o && n < 40) begin
        n++;
        @(negedge clk);
      end
      check(n == 6, "R7 reload", n, 6);
    end

    // R6: zero length cancels an open window
    @(negedge clk);
    start_i = 1'b1; len_i = LW'(6);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; len_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    #1;
    check(busy_o == 1'b0, "R6 cancel", busy_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule